// File: doc/BRIEF.md
# Dataflow Thread Wake-up Scheduler

This block is the scheduling core of a single-issue, in-order, six-stage multithreaded pipeline. It decides which thread fetches next and parks threads whose operands are not ready, without stalling the pipeline. Every architectural register has a small presence tag. A thread that reads a register whose value is still being produced by a long-latency operation is put to sleep on that register. The index of the sleeping thread is kept in the register's own data slot.

A ready queue holds the indices of runnable threads in arrival order. The fetch stage takes its next thread from the head of this queue. Threads enter the queue in two ways. The fetch side hands a thread back, either to launch it or because a compiler-marked switch point was reached. A long-latency result (multiply, floating point or load) arrives on the asynchronous completion port. It fills its register, and if a thread sleeps on that register, the thread is appended to the queue in the same cycle.

The queue has one slot per thread, so it cannot overflow as long as each thread has at most one live entry.

Top module: `dfw_sched`

## Requirements
- R1: After reset the ready queue is empty, and every register reads as present with value zero.
- R2: Threads are granted in the order in which they entered the queue. When a wake-up and a hand-back enter in the same cycle, the woken thread is placed ahead of the handed-back thread. No thread is lost and none is duplicated.
- R3: The queue holds up to NUM_THREADS entries. A grant (fetch_req while fetch_valid) removes exactly the head entry at the clock edge.
- R4: An operand check on a present register returns chk_ready=1 and the stored value, and leaves the register unchanged.
- R5: A reserve moves a present register to the outstanding state. A reserve of a register that is not present is ignored, so a thread already sleeping on that register is kept.
- R6: An operand check on an outstanding register returns chk_ready=0 and chk_data=0. The register then records the checking thread as its sleeper, and that thread is not queued.
- R7: A completion to an outstanding register with no sleeper stores the data and makes the register present, and queues nothing.
- R8: A completion to a register with a sleeper stores the data and makes the register present. It appends the sleeping thread to the queue, where it is visible from the next cycle.
- R9: When an operand check and a completion hit the same register in the same cycle, the completion wins. The check returns chk_ready=1 with the completion data, and the thread is not put to sleep.
- R10: An operand check on a register that already has a sleeper returns chk_ready=0 and leaves the recorded sleeper unchanged.
- R11: While the queue is empty, fetch_valid is 0 and fetch_tid is 0. This is the no-thread indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch takes the head thread this cycle |
| fetch_valid | output | 1 | Queue holds at least one thread |
| fetch_tid | output | TID_W | Head thread index, 0 when empty |
| rq_valid | input | 1 | Hand a thread back to the queue (launch or switch) |
| rq_tid | input | TID_W | Thread handed back |
| chk_valid | input | 1 | Operand check at decode |
| chk_reg | input | REG_W | Register checked |
| chk_tid | input | TID_W | Thread performing the check |
| chk_ready | output | 1 | Operand available this cycle |
| chk_data | output | DATA_W | Operand value, 0 when not ready |
| rsv_valid | input | 1 | Issue of a long-latency operation |
| rsv_reg | input | REG_W | Destination register of that operation |
| cmp_valid | input | 1 | Asynchronous completion write |
| cmp_reg | input | REG_W | Register written by the completion |
| cmp_data | input | DATA_W | Completion value |

## Verification
The bench builds the block with its defaults: 16 threads, 32 registers and 32-bit data. Random traffic is confined to eight of the registers, so reserves, checks and completions often collide on one register in the same cycle. Sixteen threads make it practical to fill the queue completely and to have a wake-up and a hand-back enter together. A model queue and model register tags in the bench predict every grant and every operand answer. A final drain phase completes every outstanding register and confirms that all sixteen threads are accounted for.

// File: rtl/dfw_pkg.sv
package dfw_pkg;

    // Presence tag of one register.
    typedef enum logic [1:0] {
        TAG_FULL = 2'b00,   // value present
        TAG_PEND = 2'b01,   // producer outstanding, nobody sleeping
        TAG_WAIT = 2'b10    // producer outstanding, a thread sleeps here
    } reg_tag_e;

    // Index width for a count of items (at least one bit).
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dfw_readyq.sv
module dfw_readyq
    import dfw_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TID_W = 4,
    localparam int PTR_W = idx_bits(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_valid,   // first writer (wake-up)
    input  logic [TID_W-1:0] a_tid,
    input  logic             b_valid,   // second writer (hand-back)
    input  logic [TID_W-1:0] b_tid,
    input  logic             pop,
    output logic             head_valid,
    output logic [TID_W-1:0] head_tid,
    output logic [CNT_W-1:0] count
);

    logic [TID_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q, slot_b;
    logic [CNT_W-1:0] cnt_q;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_pop     = pop && (cnt_q != '0);
    assign slot_b     = a_valid ? bump(tail_q) : tail_q;
    assign head_valid = (cnt_q != '0);
    assign head_tid   = head_valid ? slots[head_q] : '0;
    assign count      = cnt_q;

    always_ff @(posedge clk) begin
        if (a_valid) slots[tail_q] <= a_tid;
        if (b_valid) slots[slot_b] <= b_tid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (a_valid && b_valid)      tail_q <= bump(bump(tail_q));
            else if (a_valid || b_valid) tail_q <= bump(tail_q);
            if (do_pop) head_q <= bump(head_q);
            cnt_q <= cnt_q + CNT_W'(a_valid) + CNT_W'(b_valid) - CNT_W'(do_pop);
        end
    end

endmodule

// File: rtl/dfw_regtags.sv
module dfw_regtags
    import dfw_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int TID_W    = 4,
    localparam int REG_W   = idx_bits(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic [TID_W-1:0]  chk_tid,
    output logic              chk_ready,
    output logic [DATA_W-1:0] chk_data,
    input  logic              rsv_valid,
    input  logic [REG_W-1:0]  rsv_reg,
    input  logic              cmp_valid,
    input  logic [REG_W-1:0]  cmp_reg,
    input  logic [DATA_W-1:0] cmp_data,
    output logic              wake_valid,
    output logic [TID_W-1:0]  wake_tid
);

    reg_tag_e          tag_v [NUM_REGS];
    logic [DATA_W-1:0] val_v [NUM_REGS];
    logic              bypass;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        reg_tag_e          tag_r;
        logic [DATA_W-1:0] val_r;
        logic              cmp_here, chk_here, rsv_here;

        assign cmp_here = cmp_valid && (cmp_reg == REG_W'(r));
        assign chk_here = chk_valid && (chk_reg == REG_W'(r));
        assign rsv_here = rsv_valid && (rsv_reg == REG_W'(r));

        // Completion has priority, then suspension, then reservation.
        always_ff @(posedge clk) begin
            if (rst) begin
                tag_r <= TAG_FULL;
                val_r <= '0;
            end else if (cmp_here) begin
                tag_r <= TAG_FULL;
                val_r <= cmp_data;
            end else if (chk_here && tag_r == TAG_PEND) begin
                tag_r <= TAG_WAIT;
                val_r <= DATA_W'(chk_tid);
            end else if (rsv_here && tag_r == TAG_FULL) begin
                tag_r <= TAG_PEND;
            end
        end

        assign tag_v[r] = tag_r;
        assign val_v[r] = val_r;
    end

    assign bypass    = chk_valid && cmp_valid && (chk_reg == cmp_reg);
    assign chk_ready = bypass || (tag_v[chk_reg] == TAG_FULL);
    assign chk_data  = bypass    ? cmp_data :
                       chk_ready ? val_v[chk_reg] : '0;

    assign wake_valid = cmp_valid && (tag_v[cmp_reg] == TAG_WAIT);
    assign wake_tid   = val_v[cmp_reg][TID_W-1:0];

endmodule

// File: rtl/dfw_sched.sv
module dfw_sched
    import dfw_pkg::*;
#(
    parameter int NUM_THREADS = 16,
    parameter int NUM_REGS    = 32,
    parameter int DATA_W      = 32,
    localparam int TID_W      = idx_bits(NUM_THREADS),
    localparam int REG_W      = idx_bits(NUM_REGS),
    localparam int CNT_W      = $clog2(NUM_THREADS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    output logic              fetch_valid,
    output logic [TID_W-1:0]  fetch_tid,
    input  logic              rq_valid,
    input  logic [TID_W-1:0]  rq_tid,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic [TID_W-1:0]  chk_tid,
    output logic              chk_ready,
    output logic [DATA_W-1:0] chk_data,
    input  logic              rsv_valid,
    input  logic [REG_W-1:0]  rsv_reg,
    input  logic              cmp_valid,
    input  logic [REG_W-1:0]  cmp_reg,
    input  logic [DATA_W-1:0] cmp_data
);

    logic             wake_valid;
    logic [TID_W-1:0] wake_tid;
    logic [CNT_W-1:0] q_count;

    dfw_regtags #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TID_W    (TID_W)
    ) u_tags (
        .clk        (clk),
        .rst        (rst),
        .chk_valid  (chk_valid),
        .chk_reg    (chk_reg),
        .chk_tid    (chk_tid),
        .chk_ready  (chk_ready),
        .chk_data   (chk_data),
        .rsv_valid  (rsv_valid),
        .rsv_reg    (rsv_reg),
        .cmp_valid  (cmp_valid),
        .cmp_reg    (cmp_reg),
        .cmp_data   (cmp_data),
        .wake_valid (wake_valid),
        .wake_tid   (wake_tid)
    );

    // Woken thread takes the first write slot, hand-back the second.
    dfw_readyq #(
        .DEPTH (NUM_THREADS),
        .TID_W (TID_W)
    ) u_queue (
        .clk        (clk),
        .rst        (rst),
        .a_valid    (wake_valid),
        .a_tid      (wake_tid),
        .b_valid    (rq_valid),
        .b_tid      (rq_tid),
        .pop        (fetch_req),
        .head_valid (fetch_valid),
        .head_tid   (fetch_tid),
        .count      (q_count)
    );

endmodule

// File: rtl/dfw_sched_chk.sv
module dfw_sched_chk
    import dfw_pkg::*;
#(
    parameter int NUM_THREADS = 16,
    parameter int NUM_REGS    = 32,
    parameter int DATA_W      = 32,
    localparam int TID_W      = idx_bits(NUM_THREADS),
    localparam int REG_W      = idx_bits(NUM_REGS),
    localparam int CNT_W      = $clog2(NUM_THREADS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_req,
    input logic              fetch_valid,
    input logic [TID_W-1:0]  fetch_tid,
    input logic              rq_valid,
    input logic              chk_valid,
    input logic [REG_W-1:0]  chk_reg,
    input logic              chk_ready,
    input logic [DATA_W-1:0] chk_data,
    input logic              cmp_valid,
    input logic [REG_W-1:0]  cmp_reg,
    input logic [DATA_W-1:0] cmp_data,
    input logic              wake_valid,
    input logic [CNT_W-1:0]  q_count
);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNT_W'(NUM_THREADS));

    assert_grant_pops_one_R3: assert property (@(posedge clk) disable iff (rst)
        fetch_req && fetch_valid && !wake_valid && !rq_valid
        |=> q_count == $past(q_count) - 1'b1);

    assert_wake_queued_R8: assert property (@(posedge clk) disable iff (rst)
        wake_valid |=> fetch_valid);

    assert_fill_visible_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && chk_valid && $past(cmp_valid) && ($past(cmp_reg) == chk_reg)
        |-> chk_ready && ((cmp_valid && cmp_reg == chk_reg) ? chk_data == cmp_data
                                                            : chk_data == $past(cmp_data)));

    assert_empty_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && ($past(q_count) == '0) && !$past(wake_valid) && !$past(rq_valid)
        |-> !fetch_valid && (fetch_tid == '0));

endmodule

bind dfw_sched dfw_sched_chk #(
    .NUM_THREADS (NUM_THREADS),
    .NUM_REGS    (NUM_REGS),
    .DATA_W      (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_req   (fetch_req),
    .fetch_valid (fetch_valid),
    .fetch_tid   (fetch_tid),
    .rq_valid    (rq_valid),
    .chk_valid   (chk_valid),
    .chk_reg     (chk_reg),
    .chk_ready   (chk_ready),
    .chk_data    (chk_data),
    .cmp_valid   (cmp_valid),
    .cmp_reg     (cmp_reg),
    .cmp_data    (cmp_data),
    .wake_valid  (wake_valid),
    .q_count     (q_count)
);

// File: tb/dfw_sched_test.sv
module dfw_sched_test;

    localparam int NT = 16;
    localparam int NR = 32;
    localparam int DW = 32;
    localparam int TW = 4;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fetch_req = 1'b0;
    logic          fetch_valid;
    logic [TW-1:0] fetch_tid;
    logic          rq_valid = 1'b0;
    logic [TW-1:0] rq_tid = '0;
    logic          chk_valid = 1'b0;
    logic [RW-1:0] chk_reg = '0;
    logic [TW-1:0] chk_tid = '0;
    logic          chk_ready;
    logic [DW-1:0] chk_data;
    logic          rsv_valid = 1'b0;
    logic [RW-1:0] rsv_reg = '0;
    logic          cmp_valid = 1'b0;
    logic [RW-1:0] cmp_reg = '0;
    logic [DW-1:0] cmp_data = '0;

    always #5 clk = ~clk;

    dfw_sched #(.NUM_THREADS(NT), .NUM_REGS(NR), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .fetch_req(fetch_req), .fetch_valid(fetch_valid), .fetch_tid(fetch_tid),
        .rq_valid(rq_valid), .rq_tid(rq_tid),
        .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_tid(chk_tid),
        .chk_ready(chk_ready), .chk_data(chk_data),
        .rsv_valid(rsv_valid), .rsv_reg(rsv_reg),
        .cmp_valid(cmp_valid), .cmp_reg(cmp_reg), .cmp_data(cmp_data)
    );

    // Model: register tag 0 present, 1 outstanding, 2 sleeper.
    // Thread state 0 idle, 1 queued, 2 sleeping, 3 running.
    int            mst   [NR];
    logic [DW-1:0] mdat  [NR];
    int            mwait [NR];
    int            tst   [NT];
    int            mq [$];
    int            n_run  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input string note, input bit fr, input bit rv, input int rt,
                        input bit cv, input int cr, input int ct,
                        input bit sv, input int sr,
                        input bit pv, input int pr, input logic [DW-1:0] pd);
        bit            exp_fv, hit, exp_rdy;
        int            exp_ft, pre_c, pre_s, t;
        logic [DW-1:0] exp_d;
        string         ftag, ctag;
        @(negedge clk);
        fetch_req = fr;
        rq_valid  = rv;  rq_tid  = TW'(rt);
        chk_valid = cv;  chk_reg = RW'(cr); chk_tid = TW'(ct);
        rsv_valid = sv;  rsv_reg = RW'(sr);
        cmp_valid = pv;  cmp_reg = RW'(pr); cmp_data = pd;
        #1;
        exp_fv  = mq.size() > 0;
        exp_ft  = exp_fv ? mq[0] : 0;
        hit     = cv && pv && (cr == pr);
        exp_rdy = hit || (mst[cr] == 0);
        exp_d   = hit ? pd : ((mst[cr] == 0) ? mdat[cr] : '0);
        ftag = exp_fv ? "R2 grant order" : "R11 empty queue";
        ctag = hit ? "R9 same-cycle fill" : (mst[cr] == 0) ? "R4 present operand" :
               (mst[cr] == 1) ? "R6 suspend on outstanding" : "R10 second sleeper";
        check($sformatf("%s fetch_valid %s", ftag, note), 64'(fetch_valid), 64'(exp_fv));
        check($sformatf("%s fetch_tid %s", ftag, note), 64'(fetch_tid), 64'(exp_ft));
        if (cv) begin
            check($sformatf("%s chk_ready %s", ctag, note), 64'(chk_ready), 64'(exp_rdy));
            check($sformatf("%s chk_data %s", ctag, note), 64'(chk_data), 64'(exp_d));
        end
        @(posedge clk);
        pre_c = mst[cr];
        pre_s = mst[sr];
        if (fr && exp_fv) begin t = mq.pop_front(); tst[t] = 3; end
        if (pv && mst[pr] == 2) begin mq.push_back(mwait[pr]); tst[mwait[pr]] = 1; end
        if (rv) begin mq.push_back(rt); tst[rt] = 1; end
        if (pv) begin mst[pr] = 0; mdat[pr] = pd; end
        if (cv && !hit && pre_c == 1) begin mst[cr] = 2; mwait[cr] = ct; tst[ct] = 2; end
        if (sv && !(pv && pr == sr) && pre_s == 0) mst[sr] = 1;
    endtask

    task automatic idle(input string note);
        step(note, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        for (int r = 0; r < NR; r++) begin mst[r] = 0; mdat[r] = '0; mwait[r] = 0; end
        for (int t = 0; t < NT; t++) tst[t] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state seen at the ports
        chk_valid = 1'b1; chk_reg = RW'(3);
        #1;
        check("R1 fetch_valid after reset", 64'(fetch_valid), 64'd0);
        check("R1 fetch_tid after reset", 64'(fetch_tid), 64'd0);
        check("R1 register present after reset", 64'(chk_ready), 64'd1);
        check("R1 register zero after reset", 64'(chk_data), 64'd0);
        chk_valid = 1'b0;

        // R6 then R8: thread 3 sleeps on r5 and is woken
        step("launch t3", 0, 1, 3, 0, 0, 0, 0, 0, 0, 0, '0);
        step("grant t3", 1, 0, 0, 0, 0, 0, 1, 5, 0, 0, '0);
        step("R6 t3 sleeps on r5", 0, 0, 0, 1, 5, 3, 0, 0, 0, 0, '0);
        step("R8 fill r5", 0, 0, 0, 0, 0, 0, 0, 0, 1, 5, 32'h0000_ABCD);
        step("R8 woken t3 at head", 1, 0, 0, 1, 5, 0, 0, 0, 0, 0, '0);

        // R5: reserve of a register with a sleeper is ignored
        step("launch t4", 0, 1, 4, 0, 0, 0, 1, 6, 0, 0, '0);
        step("grant t4", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0);
        step("t4 sleeps on r6", 0, 0, 0, 1, 6, 4, 0, 0, 0, 0, '0);
        step("R5 reserve ignored", 0, 0, 0, 1, 6, 3, 1, 6, 0, 0, '0);
        step("R5 fill r6", 0, 0, 0, 0, 0, 0, 0, 0, 1, 6, 32'h1111_2222);
        step("R5 sleeper t4 kept and woken", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0);

        // R7: fill with no sleeper queues nothing
        step("reserve r7", 0, 0, 0, 0, 0, 0, 1, 7, 0, 0, '0);
        step("R7 fill r7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 7, 32'hDEAD_0007);
        step("R7 nothing queued", 0, 0, 0, 1, 7, 3, 0, 0, 0, 0, '0);
        check("R7 queue stays empty", 64'(fetch_valid), 64'd0);

        // R9: check and fill on the same register in one cycle
        step("reserve r8", 0, 0, 0, 0, 0, 0, 1, 8, 0, 0, '0);
        step("R9 collide r8", 0, 0, 0, 1, 8, 3, 0, 0, 1, 8, 32'h0000_0909);
        check("R9 thread not queued", 64'(fetch_valid), 64'd0);

        // R2: wake-up ahead of hand-back in the same cycle
        step("reserve r9", 0, 0, 0, 0, 0, 0, 1, 9, 0, 0, '0);
        step("t3 sleeps on r9", 0, 0, 0, 1, 9, 3, 0, 0, 0, 0, '0);
        step("R2 wake t3 with hand-back t6", 0, 1, 6, 0, 0, 0, 0, 0, 1, 9, 32'h99);
        step("R2 head t3", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0);
        step("R2 head t6", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0);

        // R3: fill the queue with every idle thread, then drain it
        for (int t = 0; t < NT; t++)
            if (tst[t] == 0) step("R3 fill", 0, 1, t, 0, 0, 0, 0, 0, 0, 0, '0);
        for (int t = 0; t < NT; t++)
            if (tst[t] == 3) step("R3 fill", 0, 1, t, 0, 0, 0, 0, 0, 0, 0, '0);
        idle("R3 full");
        check("R3 queue holds all threads", 64'(mq.size()), 64'(NT));
        for (int i = 0; i < NT; i++) step("R3 drain", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0);
        idle("R3 drained");

        // Constrained random traffic on registers 0..7
        for (int cyc = 0; cyc < 3000; cyc++) begin
            bit fr, rv, cv, sv, pv;
            int rt, cr, ct, sr, pr;
            fr = ($urandom % 100) < 40;
            cv = 0; ct = 0; cr = $urandom % 8;
            for (int k = 0; k < 6; k++) begin
                int c = $urandom % NT;
                if (!cv && tst[c] == 3 && ($urandom % 100) < 70) begin cv = 1; ct = c; end
            end
            rv = 0; rt = 0;
            for (int k = 0; k < 6; k++) begin
                int c = $urandom % NT;
                if (!rv && (tst[c] == 0 || tst[c] == 3) && !(cv && c == ct) &&
                    ($urandom % 100) < 50) begin rv = 1; rt = c; end
            end
            sv = ($urandom % 100) < 35; sr = $urandom % 8;
            pv = 0; pr = $urandom % 8;
            for (int k = 0; k < 8; k++) begin
                int c = $urandom % 8;
                if (!pv && mst[c] != 0) begin pv = ($urandom % 100) < 45; pr = c; end
            end
            if (!pv && ($urandom % 100) < 5) pv = 1;
            step("random", fr, rv, rt, cv, cr, ct, sv, sr, pv, pr, DW'($urandom));
        end

        // Drain: fill every outstanding register and grant everything
        for (int i = 0; i < 200; i++) begin
            int pr;
            bit pv;
            pv = 0; pr = 0;
            for (int r = NR - 1; r >= 0; r--) if (mst[r] != 0) begin pv = 1; pr = r; end
            step("drain", 1, 0, 0, 0, 0, 0, 0, 0, pv, pr, DW'(32'h5A00 + i));
        end
        idle("final");
        check("R2 no thread left sleeping or queued", 64'(fetch_valid), 64'd0);
        begin
            int alive = 0;
            for (int t = 0; t < NT; t++) if (tst[t] == 0 || tst[t] == 3) alive++;
            check("R2 every thread accounted for", 64'(alive), 64'(NT));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule